// File: doc/BRIEF.md
# Two-Slot Issue Packet Former

This block sits between a fetch buffer and the decode stage of a statically scheduled two-way pipeline. Each cycle it looks at up to two instruction words waiting at the head of the fetch buffer, sorts each word by its primary opcode into one of two classes, and places the words into a fixed pair of issue slots. Slot 0 is reserved for arithmetic, logic and branch work. Slot 1 is reserved for memory transfers. Slot 1 carries its base register and sign-extended offset on separate outputs, so that its own address adder can be fed directly.

When the two waiting words cannot share a packet, only the older one issues and the other slot carries a no-op. The words cannot share a packet when both fall into the same class, or when they touch a common register. The younger word stays in the buffer for the next cycle. The block reports how many buffer words it consumed, which is 0, 1 or 2, so that the buffer can advance. It also raises a fetch request whenever fewer than two words would remain after this cycle. A load that has just issued and whose destination is read by a waiting word inserts one empty packet.

The packet is registered: a decision taken in one cycle appears on the slot outputs after the next rising edge. The consumed count and the fetch request are combinational from the current inputs and the current packet.

Top module: `dual_issue_steer`

## Requirements
- R1: While reset is held low, both slot valid flags are 0 and both slot words are 0. After release with `buf_cnt` = 0, `consumed` is 0 and `fetch_ready` is 1.
- R2: Slot 0 only ever holds words whose opcode (bits 31:26) is neither 0x23 nor 0x2B. Slot 1 only ever holds words with opcode 0x23 (load) or 0x2B (store).
- R3: Two words may pair if the older (`buf_w0`) is non-memory, the younger (`buf_w1`) is memory, and the two have no register conflict. In that case `consumed` is 2 and, after the next edge, slot 0 holds `buf_w0` and slot 1 holds `buf_w1`.
- R4: Two words may also pair if the older is memory, the younger is non-memory, and the two have no register conflict. In that case `consumed` is 2 and, after the next edge, slot 0 holds `buf_w1` and slot 1 holds `buf_w0`.
- R5: A register conflict exists when a nonzero destination of either word equals a source or the destination of the other word. On a conflict, only the older word issues, in its class slot, and `consumed` is 1. The unused slot has valid 0 and word 0.
- R6: When both waiting words are in the same class, only the older issues and `consumed` is 1.
- R7: With `buf_cnt` = 1, only `buf_w0` is considered. It issues in its class slot, `consumed` is 1, and `buf_w1` has no effect.
- R8: Suppose slot 1 currently holds a valid load with a nonzero destination (bits 20:16), and that register is a source of any word being considered. Then `consumed` is 0 and the next packet is empty. The following cycle proceeds normally.
- R9: The slot 1 outputs are as follows: `s1_base` is bits 25:21 of the slot word, `s1_ofs` is bits 15:0 sign-extended to 32 bits, and `s1_load` marks a load. The slot 0 outputs `s0_ra`, `s0_rb` and `s0_dst` give the source and destination register indices, as defined in R11.
- R10: `fetch_ready` is 1 exactly when the considered word count minus `consumed` is below 2. A `buf_cnt` of 3 is treated as 2.
- R11: Register use is decoded from the opcode, where an index of 0 means none:
  - Opcode 0 reads bits 25:21 and 20:16 and writes bits 15:11.
  - Opcodes 4 and 5 read both fields and write nothing.
  - Opcode 2 uses no registers.
  - Opcode 3 writes register 31.
  - A store reads both fields.
  - A load reads bits 25:21 and writes bits 20:16.
  - Every other opcode reads bits 25:21 and writes bits 20:16.
- R12: A branch in the older position pairs with a following independent memory word in one packet, and `s0_dst` is 0 for that branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_cnt | input | 2 | Number of valid words at the buffer head (3 acts as 2) |
| buf_w0 | input | 32 | Oldest buffered word |
| buf_w1 | input | 32 | Next buffered word |
| consumed | output | 2 | Words taken from the buffer this cycle |
| fetch_ready | output | 1 | Fewer than two words remain after this cycle |
| s0_vld | output | 1 | Slot 0 holds a real instruction |
| s0_word | output | 32 | Slot 0 word (0 when empty) |
| s0_ra | output | 5 | Slot 0 first source register |
| s0_rb | output | 5 | Slot 0 second source register |
| s0_dst | output | 5 | Slot 0 destination register (0 if none) |
| s1_vld | output | 1 | Slot 1 holds a real instruction |
| s1_word | output | 32 | Slot 1 word (0 when empty) |
| s1_load | output | 1 | Slot 1 holds a load |
| s1_base | output | 5 | Slot 1 address base register |
| s1_ofs | output | 32 | Slot 1 sign-extended address offset |

## Verification
The hardest case to reach is the load-use bubble. It needs a load already sitting in slot 1 while, in the very next cycle, a dependent word is waiting at the buffer head. Between separate scenarios the bench idles one cycle, which clears the slots. The bubble scenario skips that idle cycle: it drives the load alone, then presents the dependent pair on the next falling edge. This exposes the empty packet, the zero consumed count and the withheld fetch request, followed by the normal swapped pair one cycle later.

// File: rtl/dual_issue_steer.sv
module dual_issue_steer #(
  parameter logic [5:0] OP_LOAD  = 6'h23,
  parameter logic [5:0] OP_STORE = 6'h2B,
  parameter logic [4:0] LINK_REG = 5'd31
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [1:0]  buf_cnt,
  input  logic [31:0] buf_w0,
  input  logic [31:0] buf_w1,
  output logic [1:0]  consumed,
  output logic        fetch_ready,
  output logic        s0_vld,
  output logic [31:0] s0_word,
  output logic [4:0]  s0_ra,
  output logic [4:0]  s0_rb,
  output logic [4:0]  s0_dst,
  output logic        s1_vld,
  output logic [31:0] s1_word,
  output logic        s1_load,
  output logic [4:0]  s1_base,
  output logic [31:0] s1_ofs
);

  typedef struct packed {
    logic       mem;
    logic [4:0] ra;
    logic [4:0] rb;
    logic [4:0] dst;
  } dec_t;

  function automatic dec_t decode(input logic [31:0] w);
    dec_t d;
    d.mem = 1'b0;
    d.ra  = w[25:21];
    d.rb  = 5'd0;
    d.dst = w[20:16];
    case (w[31:26])
      6'h00: begin d.rb = w[20:16]; d.dst = w[15:11]; end
      6'h04, 6'h05: begin d.rb = w[20:16]; d.dst = 5'd0; end
      6'h02: begin d.ra = 5'd0; d.dst = 5'd0; end
      6'h03: begin d.ra = 5'd0; d.dst = LINK_REG; end
      OP_STORE: begin d.mem = 1'b1; d.rb = w[20:16]; d.dst = 5'd0; end
      OP_LOAD: d.mem = 1'b1;
      default: ;
    endcase
    return d;
  endfunction

  function automatic logic hit(input logic [4:0] a, input logic [4:0] b);
    return (a != 5'd0) && (a == b);
  endfunction

  function automatic logic reads(input dec_t d, input logic [4:0] r);
    return hit(r, d.ra) || hit(r, d.rb);
  endfunction

  function automatic logic clash(input dec_t a, input dec_t b);
    return hit(a.dst, b.ra) || hit(a.dst, b.rb) || hit(a.dst, b.dst) ||
           hit(b.dst, a.ra) || hit(b.dst, a.rb);
  endfunction

  dec_t d0, d1, ds0;
  logic [1:0] n;
  logic [4:0] ld_reg;
  logic ld_live, hz0, hz1, stall;
  logic nx_s0v, nx_s1v;
  logic [31:0] nx_s0w, nx_s1w;

  assign d0  = decode(buf_w0);
  assign d1  = decode(buf_w1);
  assign n   = (buf_cnt == 2'd3) ? 2'd2 : buf_cnt;

  assign ld_reg  = s1_word[20:16];
  assign ld_live = s1_vld && (s1_word[31:26] == OP_LOAD) && (ld_reg != 5'd0);
  assign hz0     = (n != 2'd0) && reads(d0, ld_reg);
  assign hz1     = (n == 2'd2) && reads(d1, ld_reg);
  assign stall   = ld_live && (hz0 || hz1);

  always_comb begin
    nx_s0v   = 1'b0;
    nx_s0w   = '0;
    nx_s1v   = 1'b0;
    nx_s1w   = '0;
    consumed = 2'd0;
    if (!stall && n != 2'd0) begin
      if (n == 2'd2 && d0.mem != d1.mem && !clash(d0, d1)) begin
        consumed = 2'd2;
        nx_s0v   = 1'b1;
        nx_s1v   = 1'b1;
        nx_s0w   = d0.mem ? buf_w1 : buf_w0;
        nx_s1w   = d0.mem ? buf_w0 : buf_w1;
      end else begin
        consumed = 2'd1;
        if (d0.mem) begin
          nx_s1v = 1'b1;
          nx_s1w = buf_w0;
        end else begin
          nx_s0v = 1'b1;
          nx_s0w = buf_w0;
        end
      end
    end
  end

  assign fetch_ready = (n - consumed) < 2'd2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s0_vld  <= 1'b0;
      s0_word <= '0;
      s1_vld  <= 1'b0;
      s1_word <= '0;
    end else begin
      s0_vld  <= nx_s0v;
      s0_word <= nx_s0w;
      s1_vld  <= nx_s1v;
      s1_word <= nx_s1w;
    end
  end

  assign ds0     = decode(s0_word);
  assign s0_ra   = ds0.ra;
  assign s0_rb   = ds0.rb;
  assign s0_dst  = ds0.dst;
  assign s1_load = s1_vld && (s1_word[31:26] == OP_LOAD);
  assign s1_base = s1_word[25:21];
  assign s1_ofs  = {{16{s1_word[15]}}, s1_word[15:0]};

  p_slot0_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s0_vld |-> (s0_word[31:26] != OP_LOAD && s0_word[31:26] != OP_STORE));

  p_slot1_class_r2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_vld |-> (s1_word[31:26] == OP_LOAD || s1_word[31:26] == OP_STORE));

  p_pkt_matches_count_r3: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones({s0_vld, s1_vld}) == $past(consumed)));

  p_empty_is_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!s0_vld |-> s0_word == '0) and (!s1_vld |-> s1_word == '0));

  p_load_use_bubble_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_live && hz0) |=> (!s0_vld && !s1_vld));

  p_ready_when_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_cnt == 2'd0) |-> (fetch_ready && consumed == 2'd0));

endmodule

// File: tb/dual_issue_steer_tb.sv
`timescale 1ns/1ps
module dual_issue_steer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  buf_cnt = '0;
  logic [31:0] buf_w0 = '0, buf_w1 = '0;
  logic [1:0]  consumed;
  logic        fetch_ready, s0_vld, s1_vld, s1_load;
  logic [31:0] s0_word, s1_word, s1_ofs;
  logic [4:0]  s0_ra, s0_rb, s0_dst, s1_base;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  dual_issue_steer dut_i (
    .clk(clk), .rst_n(rst_n), .buf_cnt(buf_cnt), .buf_w0(buf_w0), .buf_w1(buf_w1),
    .consumed(consumed), .fetch_ready(fetch_ready),
    .s0_vld(s0_vld), .s0_word(s0_word), .s0_ra(s0_ra), .s0_rb(s0_rb), .s0_dst(s0_dst),
    .s1_vld(s1_vld), .s1_word(s1_word), .s1_load(s1_load), .s1_base(s1_base), .s1_ofs(s1_ofs)
  );

  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input int fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, 6'(fn)};
  endfunction

  function automatic logic [31:0] enc_i(input int op, input int rs, input int rt, input int imm);
    return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic run_pkt(input string tag, input logic [1:0] cnt, input logic [31:0] w0,
                         input logic [31:0] w1, input logic [1:0] ecns, input logic erdy,
                         input logic e0v, input logic [31:0] e0w,
                         input logic e1v, input logic [31:0] e1w);
    @(negedge clk);
    buf_cnt = cnt; buf_w0 = w0; buf_w1 = w1;
    #1;
    chk({tag, " consumed"}, 32'(consumed), 32'(ecns));
    chk({tag, " fetch_ready R10"}, 32'(fetch_ready), 32'(erdy));
    @(negedge clk);
    chk({tag, " s0_vld"}, 32'(s0_vld), 32'(e0v));
    chk({tag, " s0_word"}, s0_word, e0w);
    chk({tag, " s1_vld"}, 32'(s1_vld), 32'(e1v));
    chk({tag, " s1_word"}, s1_word, e1w);
    buf_cnt = 2'd0;
  endtask

  task automatic t_reset();
    chk("R1 s0_vld in reset", 32'(s0_vld), 0);
    chk("R1 s1_word in reset", s1_word, 0);
    @(negedge clk); rst_n = 1'b1; #1;
    chk("R1 consumed idle", 32'(consumed), 0);
    chk("R1 fetch_ready idle", 32'(fetch_ready), 1);
  endtask

  task automatic t_pair_inorder();
    logic [31:0] a = enc_r(1, 2, 3, 32'h20);
    logic [31:0] m = enc_i(32'h23, 5, 4, 8);
    run_pkt("R3 alu+load", 2'd2, a, m, 2'd2, 1'b1, 1'b1, a, 1'b1, m);
    chk("R9 s0_ra", 32'(s0_ra), 1);
    chk("R9 s0_rb", 32'(s0_rb), 2);
    chk("R9 s0_dst", 32'(s0_dst), 3);
    chk("R9 s1_base", 32'(s1_base), 5);
    chk("R9 s1_ofs", s1_ofs, 8);
    chk("R9 s1_load", 32'(s1_load), 1);
  endtask

  task automatic t_pair_swapped();
    logic [31:0] m = enc_i(32'h2B, 6, 7, 32'hFFFC);
    logic [31:0] a = enc_i(32'h08, 9, 8, 5);
    run_pkt("R4 store+addi swapped", 2'd2, m, a, 2'd2, 1'b1, 1'b1, a, 1'b1, m);
    chk("R9 negative offset sign-extended", s1_ofs, 32'hFFFF_FFFC);
    chk("R9 store is not load", 32'(s1_load), 0);
    chk("R11 addi dst", 32'(s0_dst), 8);
  endtask

  task automatic t_conflicts();
    logic [31:0] ld = enc_i(32'h23, 11, 10, 0);
    logic [31:0] us = enc_r(10, 13, 12, 32'h21);
    logic [31:0] ai = enc_i(32'h08, 0, 4, 1);
    logic [31:0] lw = enc_i(32'h23, 2, 4, 0);
    run_pkt("R5 load then reader", 2'd2, ld, us, 2'd1, 1'b1, 1'b0, 0, 1'b1, ld);
    run_pkt("R5 same destination", 2'd2, ai, lw, 2'd1, 1'b1, 1'b1, ai, 1'b0, 0);
  endtask

  task automatic t_same_class();
    logic [31:0] a = enc_r(1, 2, 3, 32'h20);
    logic [31:0] b = enc_r(4, 5, 6, 32'h22);
    logic [31:0] m0 = enc_i(32'h23, 1, 7, 4);
    logic [31:0] m1 = enc_i(32'h2B, 2, 8, 12);
    run_pkt("R6 alu+alu", 2'd2, a, b, 2'd1, 1'b1, 1'b1, a, 1'b0, 0);
    run_pkt("R6 R2 load+store", 2'd2, m0, m1, 2'd1, 1'b1, 1'b0, 0, 1'b1, m0);
  endtask

  task automatic t_single();
    logic [31:0] st = enc_i(32'h2B, 3, 9, 16);
    logic [31:0] a  = enc_r(1, 2, 3, 32'h24);
    logic [31:0] jl = {6'h03, 26'h0000100};
    run_pkt("R7 lone store, w1 ignored", 2'd1, st, a, 2'd1, 1'b1, 1'b0, 0, 1'b1, st);
    run_pkt("R7 lone alu", 2'd1, a, st, 2'd1, 1'b1, 1'b1, a, 1'b0, 0);
    run_pkt("R11 jal", 2'd1, jl, 0, 2'd1, 1'b1, 1'b1, jl, 1'b0, 0);
    chk("R11 jal writes link register", 32'(s0_dst), 31);
  endtask

  task automatic t_load_use();
    logic [31:0] ld = enc_i(32'h23, 1, 5, 4);
    logic [31:0] st = enc_i(32'h2B, 2, 9, 0);
    logic [31:0] us = enc_r(5, 3, 7, 32'h20);
    @(negedge clk);
    buf_cnt = 2'd1; buf_w0 = ld; buf_w1 = 0;
    #1 chk("R8 load issues", 32'(consumed), 1);
    @(negedge clk);
    chk("R8 load in slot1", s1_word, ld);
    buf_cnt = 2'd2; buf_w0 = st; buf_w1 = us;
    #1;
    chk("R8 bubble consumed", 32'(consumed), 0);
    chk("R8 R10 no fetch during bubble", 32'(fetch_ready), 0);
    @(negedge clk);
    chk("R8 empty packet s0", 32'(s0_vld), 0);
    chk("R8 empty packet s1", 32'(s1_vld), 0);
    #1 chk("R8 resumes consumed", 32'(consumed), 2);
    @(negedge clk);
    chk("R8 R4 resumed s0", s0_word, us);
    chk("R8 R4 resumed s1", s1_word, st);
    buf_cnt = 2'd0;
  endtask

  task automatic t_branch_and_count();
    logic [31:0] br = enc_i(32'h04, 1, 2, 3);
    logic [31:0] ld = enc_i(32'h23, 4, 3, 0);
    logic [31:0] a  = enc_r(1, 2, 3, 32'h20);
    logic [31:0] b  = enc_r(4, 5, 6, 32'h25);
    run_pkt("R12 branch+load", 2'd2, br, ld, 2'd2, 1'b1, 1'b1, br, 1'b1, ld);
    chk("R12 branch has no dst", 32'(s0_dst), 0);
    run_pkt("R10 cnt3 acts as 2", 2'd3, a, b, 2'd1, 1'b1, 1'b1, a, 1'b0, 0);
  endtask

  initial begin
    repeat (1000000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog R1..: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_pair_inorder();
    t_pair_swapped();
    t_conflicts();
    t_same_class();
    t_single();
    t_load_use();
    t_branch_and_count();
    repeat (2) @(negedge clk);
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule